// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave with Timed Write Cycle

This block is the slave side of a two-wire serial memory. The storage is a register array inside the block. The block watches a slow serial clock (SCL) and an open-drain data line (SDA) and detects start and stop conditions from them. It answers only to its own 7-bit device address. A two-byte memory address is loaded into an address counter, and that counter keeps its value between transactions.

Write data goes into a page buffer first. The buffer is copied into the array only when a stop condition ends the write. After the copy the block spends a fixed number of system clocks in a write cycle. During that cycle it does not acknowledge its own address, so a host polls the acknowledge bit to find out when the cycle has finished.

Three kinds of read are supported:
- a current-address read, which starts at the saved counter;
- a random read, which is a dummy write of the address followed by a repeated start;
- a sequential read, which goes on for as long as the host acknowledges each byte.

Top module: `eep_i2c_slave`

## Requirements
- R1: After reset, SDA is released (`sdaLow` = 0), the address counter is 0 and every memory byte reads 8'hFF.
- R2: The block samples SDA on a rising SCL. A falling SDA while SCL is high is a start, and a rising SDA while SCL is high is a stop. The block changes `sdaLow` only while SCL is low.
- R3: The first byte after a start holds the device address in bits 7..1 and the direction in bit 0 (0 = write, 1 = read). The block pulls SDA low on the ninth clock only if bits 7..1 equal `DEV_ADDR`. Otherwise it leaves SDA released and ignores the bus until the next start or stop.
- R4: In a write, the next two bytes are the memory address, upper byte first, then lower byte. The address counter takes the low `MEM_AW` bits of that 16-bit value.
- R5: Every data byte of a write is acknowledged and stored in a page buffer. The low `PAGE_AW` bits of the counter advance and wrap inside the page. The array is not changed until the stop condition.
- R6: A stop that ends a write carrying at least one data byte copies the buffered bytes into the array and starts a write cycle of exactly `WR_CYCLES` clocks. A write with no data bytes starts no cycle. A write cut short by a repeated start starts no cycle and discards its data.
- R7: During the write cycle the device address byte is not acknowledged, with either direction bit. Once the cycle is over it is acknowledged again.
- R8: The address counter holds the last accessed address plus one. A current-address read returns the byte at the counter, most significant bit first.
- R9: A random read (address write, repeated start, read address byte) returns the byte at the address just written.
- R10: A read continues with the next byte while the host answers 0. The counter wraps from the last memory byte to 0. An answer of 1 followed by a stop ends the read with SDA released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| scl | input | 1 | Serial clock from the host |
| sdaIn | input | 1 | Level of the data line as seen on the bus |
| sdaLow | output | 1 | When 1, the open-drain driver pulls SDA low |

## Verification
The bench applies every one of the 128 device addresses and expects exactly one acknowledge. A decoder that ignored an address bit would acknowledge extra addresses. The bench runs page writes that overrun the page end by three bytes. A design that carried into the page number would corrupt the next page, and a design that wrote at each byte instead of at the stop would give a different image. It polls right after each stop and again after the write cycle, which catches a busy flag that is missing or never clears. It also checks that a write cut off by a repeated start leaves memory untouched and starts no write cycle. Finally, one sequential read covers the whole array and crosses its end. Counter carry, the byte order of the address and wrap faults all show up there as wrong data.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DEV,
    S_AHI,
    S_ALO,
    S_WDAT,
    S_ACK,
    S_RD,
    S_RACK
  } phase_t;

  // strobes from control to datapath, one clock wide
  typedef struct packed {
    logic startEv;
    logic stopEv;
    logic shiftIn;
    logic loadHi;
    logic loadLo;
    logic wrByte;
    logic loadTx;
    logic shiftTx;
  } strobe_t;

endpackage

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       scl,
  input  logic       sdaIn,
  input  logic [7:0] rxByte,
  input  logic       busy,
  output strobe_t    strb,
  output logic       sdaBit,
  output logic       ackDrive,
  output logic       rdDrive
);

  logic [2:0] sclSync, sdaSync;
  logic sclQ, sclP, sdaQ, sdaP;
  logic sclRise, sclFall, evNone, rxPhase, byteDone, devHit;
  phase_t state, afterAck;
  logic [3:0] bitCnt;
  logic masterNack;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 3'b111;
      sdaSync <= 3'b111;
    end else begin
      sclSync <= {sclSync[1:0], scl};
      sdaSync <= {sdaSync[1:0], sdaIn};
    end
  end

  assign sclQ = sclSync[1];
  assign sclP = sclSync[2];
  assign sdaQ = sdaSync[1];
  assign sdaP = sdaSync[2];
  assign sdaBit = sdaQ;

  assign sclRise = sclQ & ~sclP;
  assign sclFall = ~sclQ & sclP;

  always_comb begin
    strb = '0;
    strb.startEv = sclQ & sclP & sdaP & ~sdaQ;
    strb.stopEv  = sclQ & sclP & ~sdaP & sdaQ;
    evNone   = ~strb.startEv & ~strb.stopEv;
    rxPhase  = (state == S_DEV) || (state == S_AHI) || (state == S_ALO) || (state == S_WDAT);
    strb.shiftIn = evNone & rxPhase & sclRise & (bitCnt != 4'd8);
    byteDone = evNone & rxPhase & sclFall & (bitCnt == 4'd8);
    strb.loadHi = byteDone & (state == S_AHI);
    strb.loadLo = byteDone & (state == S_ALO);
    strb.wrByte = byteDone & (state == S_WDAT);
    strb.loadTx = evNone & sclFall &
                  (((state == S_ACK) && (afterAck == S_RD)) || ((state == S_RACK) && !masterNack));
    strb.shiftTx = evNone & sclFall & (state == S_RD) & (bitCnt != 4'd8);
  end

  assign devHit   = (rxByte[7:1] == DEV_ADDR) && !busy;
  assign ackDrive = (state == S_ACK);
  assign rdDrive  = (state == S_RD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      afterAck   <= S_IDLE;
      bitCnt     <= 4'd0;
      masterNack <= 1'b0;
    end else if (strb.startEv) begin
      state  <= S_DEV;
      bitCnt <= 4'd0;
    end else if (strb.stopEv) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_DEV, S_AHI, S_ALO, S_WDAT: begin
          if (strb.shiftIn) bitCnt <= bitCnt + 4'd1;
          if (byteDone) begin
            state <= S_ACK;
            case (state)
              S_DEV: begin
                if (devHit) afterAck <= rxByte[0] ? S_RD : S_AHI;
                else        state    <= S_IDLE;
              end
              S_AHI:   afterAck <= S_ALO;
              default: afterAck <= S_WDAT;
            endcase
          end
        end
        S_ACK: begin
          if (sclFall) begin
            state  <= afterAck;
            bitCnt <= 4'd0;
          end
        end
        S_RD: begin
          if (sclRise && bitCnt != 4'd8) bitCnt <= bitCnt + 4'd1;
          if (sclFall && bitCnt == 4'd8) state <= S_RACK;
        end
        S_RACK: begin
          if (sclRise) masterNack <= sdaQ;
          if (sclFall) begin
            state  <= masterNack ? S_IDLE : S_RD;
            bitCnt <= 4'd0;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/eep_datapath.sv
module eep_datapath
  import eep_pkg::*;
#(
  parameter int MEM_AW    = 9,
  parameter int PAGE_AW   = 4,
  parameter int WR_CYCLES = 5000
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    strb,
  input  logic       sdaBit,
  output logic [7:0] rxByte,
  output logic       txBit,
  output logic       busy,
  output logic       maskAny
);

  localparam int MEM_DEPTH = 1 << MEM_AW;
  localparam int PAGE      = 1 << PAGE_AW;
  localparam int CW        = $clog2(WR_CYCLES + 1);

  logic [7:0] rxShift, txShift, addrHi;
  logic [MEM_AW-1:0] ptr;
  logic [7:0] mem [MEM_DEPTH];
  logic [7:0] pbuf [PAGE];
  logic [PAGE-1:0] pmask;
  logic [CW-1:0] busyCnt;
  logic [15:0] fullAddr;
  logic unusedAddrBits;
  logic commit;

  assign fullAddr = {addrHi, rxShift};
  assign unusedAddrBits = ^fullAddr;
  assign commit  = strb.stopEv & maskAny;
  assign rxByte  = rxShift;
  assign txBit   = txShift[7];
  assign busy    = (busyCnt != '0);
  assign maskAny = |pmask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= 8'h00;
      txShift <= 8'hFF;
      addrHi  <= 8'h00;
      ptr     <= '0;
    end else begin
      if (strb.shiftIn) rxShift <= {rxShift[6:0], sdaBit};
      if (strb.loadHi) addrHi <= rxShift;
      if (strb.loadLo) ptr <= fullAddr[MEM_AW-1:0];
      if (strb.wrByte) ptr[PAGE_AW-1:0] <= ptr[PAGE_AW-1:0] + 1'b1;
      if (strb.loadTx) begin
        txShift <= mem[ptr];
        ptr     <= ptr + 1'b1;
      end else if (strb.shiftTx) begin
        txShift <= {txShift[6:0], 1'b1};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.wrByte) pbuf[ptr[PAGE_AW-1:0]] <= rxShift;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pmask   <= '0;
      busyCnt <= '0;
      for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      if (strb.startEv) begin
        pmask <= '0;
      end else if (commit) begin
        pmask <= '0;
        for (int i = 0; i < PAGE; i++)
          if (pmask[i]) mem[{ptr[MEM_AW-1:PAGE_AW], i[PAGE_AW-1:0]}] <= pbuf[i];
      end else if (strb.wrByte) begin
        pmask[ptr[PAGE_AW-1:0]] <= 1'b1;
      end
      if (commit) busyCnt <= CW'(WR_CYCLES);
      else if (busy) busyCnt <= busyCnt - 1'b1;
    end
  end

endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave
  import eep_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h50,
  parameter int         MEM_AW    = 9,
  parameter int         PAGE_AW   = 4,
  parameter int         WR_CYCLES = 5000
) (
  input  logic clk,
  input  logic rstN,
  input  logic scl,
  input  logic sdaIn,
  output logic sdaLow
);

  strobe_t    strb;
  logic [7:0] rxByte;
  logic       sdaBit, busy, maskAny, txBit, ackDrive, rdDrive;

  eep_ctrl #(.DEV_ADDR(DEV_ADDR)) i_ctrl (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaIn),
    .rxByte(rxByte), .busy(busy), .strb(strb), .sdaBit(sdaBit),
    .ackDrive(ackDrive), .rdDrive(rdDrive)
  );

  eep_datapath #(.MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW), .WR_CYCLES(WR_CYCLES)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaBit(sdaBit),
    .rxByte(rxByte), .txBit(txBit), .busy(busy), .maskAny(maskAny)
  );

  assign sdaLow = ackDrive | (rdDrive & ~txBit);

endmodule

// File: rtl/eep_i2c_checker.sv
module eep_i2c_checker #(
  parameter int WR_CYCLES = 5000
) (
  input logic clk,
  input logic rstN,
  input logic scl,
  input logic sdaLow,
  input logic busy,
  input logic ackDrive,
  input logic startEv,
  input logic stopEv,
  input logic maskAny
);

  localparam int RW = $clog2(WR_CYCLES + 2);
  logic [RW-1:0] busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else           busyRun <= '0;
  end

  p_sda_scl_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    (scl && $past(scl)) |-> $stable(sdaLow));

  p_commit_on_stop_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopEv));

  p_cycle_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyRun == RW'(WR_CYCLES)));

  p_start_drops_data_r6: assert property (@(posedge clk) disable iff (!rstN)
    startEv |=> !maskAny);

  p_busy_nack_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !ackDrive);

endmodule

bind eep_i2c_slave eep_i2c_checker #(.WR_CYCLES(WR_CYCLES)) i_chk (
  .clk(clk), .rstN(rstN), .scl(scl), .sdaLow(sdaLow), .busy(busy),
  .ackDrive(ackDrive), .startEv(strb.startEv), .stopEv(strb.stopEv),
  .maskAny(maskAny)
);

// File: tb/test_eep_i2c_slave.sv
module test_eep_i2c_slave;

  localparam logic [6:0] DEV = 7'h51;
  localparam int AW  = 9;
  localparam int PW  = 3;
  localparam int WRC = 300;
  localparam int Q   = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic sdaLow;
  logic sdaLine;
  int vectors = 0;
  int fails = 0;
  logic [7:0] model [DEPTH];
  int mPtr;

  always #10 clk = ~clk;
  assign sdaLine = mSda & ~sdaLow;

  eep_i2c_slave #(.DEV_ADDR(DEV), .MEM_AW(AW), .PAGE_AW(PW), .WR_CYCLES(WRC)) i_eep_i2c_slave (
    .clk(clk), .rstN(rstN), .scl(mScl), .sdaIn(sdaLine), .sdaLow(sdaLow)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busStart();
    mSda = 1'b1; tick(Q);
    mScl = 1'b1; tick(Q);
    mSda = 1'b0; tick(Q);
    mScl = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    mSda = 1'b0; tick(Q);
    mScl = 1'b1; tick(Q);
    mSda = 1'b1; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; tick(Q);
      mScl = 1'b1; tick(Q);
      mScl = 1'b0; tick(Q);
    end
    mSda = 1'b1; tick(Q);
    mScl = 1'b1; tick(Q);
    ack = sdaLine;
    mScl = 1'b0; tick(Q);
  endtask

  task automatic recvByte(input logic nack, output logic [7:0] b);
    mSda = 1'b1;
    b = 8'h00;
    for (int i = 0; i < 8; i++) begin
      tick(Q);
      mScl = 1'b1; tick(Q);
      b = {b[6:0], sdaLine};
      mScl = 1'b0;
    end
    tick(Q);
    mSda = nack; tick(Q);
    mScl = 1'b1; tick(Q);
    mScl = 1'b0; tick(Q);
    mSda = 1'b1;
  endtask

  task automatic setAddr(input int addr, input string tag);
    logic a;
    busStart();
    sendByte({DEV, 1'b0}, a); chk({tag, " dev ack"}, a, 0);
    sendByte(8'((addr >> 8) & 255), a); chk({tag, " hi ack"}, a, 0);
    sendByte(8'(addr & 255), a); chk({tag, " lo ack"}, a, 0);
  endtask

  task automatic curRead(input string tag);
    logic a;
    logic [7:0] d;
    busStart();
    sendByte({DEV, 1'b1}, a); chk({tag, " dev ack"}, a, 0);
    recvByte(1'b1, d);
    chk({tag, " data"}, d, model[mPtr]);
    busStop();
    mPtr = (mPtr + 1) % DEPTH;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    mPtr = 0;
    tick(5);
    rstN = 1'b1;
    tick(3);
    // R1: line released after reset
    chk("R1 sdaLow after reset", sdaLow, 0);

    // R3: every device address, write direction; only DEV acknowledged
    for (int adr = 0; adr < 128; adr++) begin
      busStart();
      sendByte({adr[6:0], 1'b0}, a);
      chk("R3 address sweep", a, (adr == DEV) ? 0 : 1);
      busStop();
    end

    // R6: the write above had no data, so no write cycle is running
    busStart();
    sendByte({DEV, 1'b0}, a);
    chk("R6 no cycle without data", a, 0);
    busStop();

    // R1/R8: counter starts at 0, erased content
    curRead("R1 R8 first read");

    // R5 page writes with wrap, R7 polling, R8 counter after write
    for (int k = 0; k <= 20; k++) begin
      int page, off, cnt, base;
      page = (k == 20) ? 63 : k * 3;
      off  = k % 8;
      cnt  = (k == 5) ? 11 : ((k == 7) ? 1 : 8);
      base = page * 8;
      setAddr(base + off, "R4 write address");
      for (int i = 0; i < cnt; i++) begin
        logic [7:0] wd;
        wd = 8'((k * 29 + i * 7 + 1) & 255);
        sendByte(wd, a);
        chk("R5 data ack", a, 0);
        model[base + ((off + i) % 8)] = wd;
      end
      busStop();
      mPtr = base + ((off + cnt) % 8);
      busStart();
      sendByte({DEV, 1'b0}, a);
      chk("R7 poll during cycle", a, 1);
      busStop();
      if (k == 0) begin
        busStart();
        sendByte({DEV, 1'b1}, a);
        chk("R7 read poll during cycle", a, 1);
        busStop();
      end
      tick(WRC);
      busStart();
      sendByte({DEV, 1'b0}, a);
      chk("R7 poll after cycle", a, 0);
      busStop();
      if (k % 2 == 1) curRead("R8 current read after write");
    end

    // R6: write interrupted by repeated start is discarded, no cycle
    setAddr(9'h0A2, "R6 cut write");
    sendByte(8'h5A, a); chk("R6 cut data ack", a, 0);
    busStart();
    sendByte({DEV, 1'b0}, a);
    chk("R6 no cycle after repeated start", a, 0);
    busStop();
    busStart();
    sendByte({DEV, 1'b0}, a);
    chk("R6 still idle", a, 0);
    busStop();

    // R9: random read of the cut address shows old content
    setAddr(9'h0A2, "R9 random");
    busStart();
    sendByte({DEV, 1'b1}, a); chk("R9 read ack", a, 0);
    recvByte(1'b1, d);
    chk("R9 random read data", d, model[9'h0A2]);
    busStop();

    // R4: upper byte first selects address 0x123
    setAddr(9'h123, "R4 order");
    busStart();
    sendByte({DEV, 1'b1}, a); chk("R4 read ack", a, 0);
    recvByte(1'b1, d);
    chk("R4 address byte order", d, model[9'h123]);
    busStop();

    // R10: sequential read over the whole array with wrap
    setAddr(9'h1F8, "R10 seq");
    busStart();
    sendByte({DEV, 1'b1}, a); chk("R10 read ack", a, 0);
    for (int i = 0; i < 520; i++) begin
      recvByte((i == 519) ? 1'b1 : 1'b0, d);
      chk("R10 sequential data", d, model[(9'h1F8 + i) % DEPTH]);
    end
    busStop();
    tick(2);
    chk("R10 released after stop", sdaLow, 0);
    mPtr = (9'h1F8 + 520) % DEPTH;
    curRead("R8 current read after sequential");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule